// File: doc/BRIEF.md
# Two-Register Buffered PWM Timer

This block generates a pulse-width-modulated output from a prescaled 16-bit up-counter. The counter runs from zero up to a programmable period value and then wraps to zero. Each wrap is flagged by a one-cycle overflow strobe. One output channel compares the counter against a compare register. On a match it forces the output to a programmed level. On each wrap it can toggle the output, so the pulse starts at every period boundary and ends at the compare point.

The channel runs in one of two modes. In single-register mode, compare register A alone sets the pulse width. In paired mode, registers A and B take turns as the active compare value. Software loads the idle register while the other one is in use. The channel switches to the newly loaded value only when the counter wraps, so a width change never cuts a period short or stretches it. A write to the register that is in use takes effect at once, with no swap.

Software programs the block through a write port with five addresses. To start it, software halts the counter and clears it, programs the period, the compare value and the channel configuration, and then releases the halt.

Top module: `pwm_pair_timer`

## Requirements
- R1: The counter advances by one on every prescaled tick. On a tick where the counter equals the period register (address 1), it returns to 0. `ovf_strobe` is high only during that tick cycle, so it is a single-cycle pulse whenever the period is non-zero.
- R2: Control field bits [4:2] at address 0 select the tick rate. A value s from 0 to 6 gives one tick every 2^s clock cycles, counted from the cycle in which the halt is released.
- R3: Control bit 0 at address 0 halts the counter and the prescaler while it is 1. It is 1 after reset. Writing control bit 1 as 1 zeroes the counter and the prescaler at that write edge. Bit 1 is not stored.
- R4: When configuration bit 4 at address 4 is set, the output toggles on every counter wrap. The exception is a wrap that coincides with a compare match, where the compare action wins.
- R5: Configuration bits [3:2] select the compare action. 2'b10 drives the output to 0 on a match and 2'b11 drives it to 1. A match is a tick on which the counter equals the active compare value c. With toggling enabled and c below the period P, the output holds the pulse level (the opposite of the compare level) for (c+1)·2^s of every (P+1)·2^s cycles. With c equal to P, the output holds the compare level constantly.
- R6: A compare value larger than the period never matches. With toggling enabled, the output then changes only at wraps, so it is high for exactly half of any two-period window.
- R7: Configuration bits [1:0] = 2'b01 select single-register mode. Only compare register A (address 2) sets the width. Writes to register B (address 3) have no effect on the output.
- R8: Configuration bits [1:0] = 2'b10 select paired mode, with A active after reset. A write to the idle register leaves the current period's width unchanged. The written register becomes the active one at the next counter wrap.
- R9: In paired mode, a write to the active register changes the width from the next compare in the same period. No swap follows.
- R10: After reset, `pwm_out`, `count` and `ovf_strobe` are 0, and the counter stays at 0 until the halt is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address: 0 control, 1 period, 2 compare A, 3 compare B, 4 channel configuration |
| wr_data | input | CNT_W (16) | Write data |
| pwm_out | output | 1 | PWM output |
| ovf_strobe | output | 1 | High during the tick cycle in which the counter wraps |
| count | output | CNT_W (16) | Current counter value |

## Verification
All register writes land on the clock edge that follows the write strobe. The bench drives the strobe on a falling edge, so every new setting is visible at the next falling-edge sample. The output and the counter change on the tick edge, one cycle after the cycle in which the counter held the compare or period value. A pulse therefore covers the samples in which the counter reads 0 through c. The bench counts high samples over whole-period windows that begin at the sample right after a seen overflow strobe, and runs two settling periods before each window. For the buffered cases it places the write at the edge where the counter moves from 0 to 1. It then counts the remaining nine samples of that period separately from the next full period, so a deferred update and an immediate update give different expected counts.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Register map of the write port
    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_PERIOD = 3'd1,
        REG_CMPA   = 3'd2,
        REG_CMPB   = 3'd3,
        REG_CHCFG  = 3'd4
    } reg_addr_e;

    // Control word bit positions
    localparam int CTRL_HALT_BIT = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_SEL_LSB  = 2;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_PAIR   = 2'b10,
        MODE_RSVD   = 2'b11
    } ch_mode_e;

    // Channel configuration word: {tov, els[1:0], mode[1:0]}
    typedef struct packed {
        logic       tov;
        logic [1:0] els;
        ch_mode_e   mode;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
    parameter int PS_LOG_MAX = 6,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [PS_LOG_MAX-1:0] div_q;
    logic [PS_LOG_MAX-1:0] mask;

    // Low 'sel' bits of the divider must all be set for a tick
    always_comb begin
        for (int i = 0; i < PS_LOG_MAX; i++) begin
            mask[i] = (int'(sel_i) > i);
        end
    end

    assign tick_o = run_i && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            div_q <= '0;
        end else if (run_i) begin
            div_q <= div_q + 1'b1;
        end
    end

    // R2
    undivided_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && sel_i == '0) |-> tick_o);

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    logic [CNT_W-1:0] cnt_q;

    assign ovf_o = tick_i && (cnt_q == period_i);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (ovf_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> (cnt_q == '0));

    // R1
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> (!ovf_o || period_i == '0));

    // R3
    frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_cfg_t          cfg_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic             wr_a_i,
    input  logic             wr_b_i,
    input  logic             tick_i,
    input  logic             ovf_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pwm_o
);

    logic             pwm_q;
    logic             act_b_q;   // paired mode: B is the live compare value
    logic             pend_q;    // idle register loaded, swap at next wrap
    logic             pair;
    logic             en;
    logic             hit;
    logic             wr_idle;
    logic             swap;
    logic [CNT_W-1:0] cmp_act;

    assign pair    = (cfg_i.mode == MODE_PAIR);
    assign en      = (cfg_i.mode != MODE_OFF) && cfg_i.els[1];
    assign cmp_act = (pair && act_b_q) ? cmp_b_i : cmp_a_i;
    assign hit     = en && tick_i && (cnt_i == cmp_act);
    assign wr_idle = pair && (act_b_q ? wr_a_i : wr_b_i);
    assign swap    = pair && ovf_i && pend_q;
    assign pwm_o   = pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q   <= 1'b0;
            act_b_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (swap) begin
                act_b_q <= ~act_b_q;
            end
            pend_q <= swap ? 1'b0 : (pend_q | wr_idle);
            if (hit) begin
                pwm_q <= cfg_i.els[0];
            end else if (en && cfg_i.tov && ovf_i) begin
                pwm_q <= ~pwm_q;
            end
        end
    end

    // R8
    swap_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !ovf_i |=> $stable(act_b_q));

    // R4
    wrap_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cfg_i.tov && ovf_i && cnt_i != cmp_act) |=> (pwm_q != $past(pwm_q)));

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PS_LOG_MAX = 6,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic              ovf_strobe,
    output logic [CNT_W-1:0]  count
);

    localparam int SEL_W = $clog2(PS_LOG_MAX + 1);

    logic             halt_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cmp_a_q;
    logic [CNT_W-1:0] cmp_b_q;
    ch_cfg_t          cfg_q;

    logic wr_ctrl, wr_per, wr_a, wr_b, wr_cfg;
    logic clr_pulse, tick, ovf;

    assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign wr_per    = wr_en && (wr_addr == ADDR_W'(REG_PERIOD));
    assign wr_a      = wr_en && (wr_addr == ADDR_W'(REG_CMPA));
    assign wr_b      = wr_en && (wr_addr == ADDR_W'(REG_CMPB));
    assign wr_cfg    = wr_en && (wr_addr == ADDR_W'(REG_CHCFG));
    assign clr_pulse = wr_ctrl && wr_data[CTRL_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q   <= 1'b1;
            sel_q    <= '0;
            period_q <= '1;
            cmp_a_q  <= '1;
            cmp_b_q  <= '1;
            cfg_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                halt_q <= wr_data[CTRL_HALT_BIT];
                sel_q  <= wr_data[CTRL_SEL_LSB +: SEL_W];
            end
            if (wr_per) period_q <= wr_data;
            if (wr_a)   cmp_a_q  <= wr_data;
            if (wr_b)   cmp_b_q  <= wr_data;
            if (wr_cfg) cfg_q    <= ch_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    pwmt_prescale #(
        .PS_LOG_MAX (PS_LOG_MAX),
        .SEL_W      (SEL_W)
    ) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run_i  (!halt_q),
        .clr_i  (clr_pulse),
        .sel_i  (sel_q),
        .tick_o (tick)
    );

    pwmt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .clr_i    (clr_pulse),
        .period_i (period_q),
        .cnt_o    (count),
        .ovf_o    (ovf)
    );

    pwmt_channel #(
        .CNT_W (CNT_W)
    ) u_ch (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg_q),
        .cmp_a_i (cmp_a_q),
        .cmp_b_i (cmp_b_q),
        .wr_a_i  (wr_a),
        .wr_b_i  (wr_b),
        .tick_i  (tick),
        .ovf_i   (ovf),
        .cnt_i   (count),
        .pwm_o   (pwm_out)
    );

    assign ovf_strobe = ovf;

    // R3
    halted_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        halt_q |-> !ovf_strobe);

endmodule

// File: tb/tb_pwm_pair_timer.sv
`timescale 1ns/1ps
module tb_pwm_pair_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic        ovf_strobe;
    logic [15:0] count;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwm_pair_timer dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .ovf_strobe (ovf_strobe),
        .count      (count)
    );

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] cmp;
        logic [2:0]  sel;
        logic        set_on_cmp;
        logic [15:0] exp_hi;   // high samples over two periods
    } vec_t;

    // R5 widths, R2 rates, R6 out-of-range compare, R4 toggling on wrap
    localparam vec_t VECS [9] = '{
        '{16'd9, 16'd3,  3'd0, 1'b0, 16'd8},
        '{16'd9, 16'd0,  3'd0, 1'b0, 16'd2},
        '{16'd7, 16'd2,  3'd1, 1'b0, 16'd12},
        '{16'd4, 16'd1,  3'd2, 1'b0, 16'd16},
        '{16'd9, 16'd9,  3'd0, 1'b0, 16'd0},
        '{16'd9, 16'd3,  3'd0, 1'b1, 16'd12},
        '{16'd5, 16'd5,  3'd0, 1'b1, 16'd12},
        '{16'd3, 16'd0,  3'd6, 1'b0, 16'd128},
        '{16'd9, 16'd20, 3'd0, 1'b0, 16'd10}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic setup(input logic [15:0] per, input logic [15:0] cmpa,
                         input logic [2:0] sel, input logic [1:0] mode,
                         input logic set_on_cmp);
        wr(3'd0, {11'd0, sel, 2'b11});
        wr(3'd1, per);
        wr(3'd2, cmpa);
        wr(3'd4, {11'd0, 1'b1, 1'b1, set_on_cmp, mode});
        wr(3'd0, {11'd0, sel, 2'b00});
    endtask

    task automatic count_hi(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) h++;
            @(negedge clk);
        end
    endtask

    task automatic wait_strobe();
        @(negedge clk);
        while (ovf_strobe !== 1'b1) @(negedge clk);
    endtask

    task automatic measure_period(input int per, output int h);
        wait_strobe();
        @(negedge clk);
        count_hi(per + 1, h);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int h, c0, mx, novf, dbl, badwrap;
        logic prev_ovf;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 pwm_out", int'(pwm_out), 0);
        chk("R10 count", int'(count), 0);
        chk("R10 ovf_strobe", int'(ovf_strobe), 0);
        repeat (5) @(negedge clk);
        chk("R10 halted after reset", int'(count), 0);

        // R1 wrap and strobe
        setup(16'd4, 16'd9, 3'd0, 2'b01, 1'b0);
        mx = 0; novf = 0; dbl = 0; badwrap = 0; prev_ovf = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (prev_ovf && count != 16'd0) badwrap++;
            if (int'(count) > mx) mx = int'(count);
            if (ovf_strobe) novf++;
            if (ovf_strobe && prev_ovf) dbl++;
            prev_ovf = ovf_strobe;
            @(negedge clk);
        end
        chk("R1 max count", mx, 4);
        chk("R1 strobes in 20 cycles", novf, 4);
        chk("R1 back-to-back strobes", dbl, 0);
        chk("R1 zero after strobe", badwrap, 0);

        // R3 halt and clear
        setup(16'd100, 16'd200, 3'd0, 2'b01, 1'b0);
        repeat (5) @(negedge clk);
        wr(3'd0, {11'd0, 3'd0, 2'b01});
        c0 = int'(count);
        repeat (10) @(negedge clk);
        chk("R3 halted count drift", int'(count) - c0, 0);
        wr(3'd0, {11'd0, 3'd0, 2'b11});
        chk("R3 clear", int'(count), 0);
        wr(3'd0, {11'd0, 3'd0, 2'b00});
        repeat (3) @(negedge clk);
        chk("R3 restart count", int'(count), 3);

        // R2 divide by 8
        wr(3'd0, {11'd0, 3'd3, 2'b11});
        wr(3'd0, {11'd0, 3'd3, 2'b00});
        repeat (16) @(negedge clk);
        chk("R2 divide-by-8 count", int'(count), 2);

        // Vector table: R2 R4 R5 R6
        for (int v = 0; v < 9; v++) begin
            int win;
            win = (int'(VECS[v].per) + 1) << VECS[v].sel;
            setup(VECS[v].per, VECS[v].cmp, VECS[v].sel, 2'b01, VECS[v].set_on_cmp);
            repeat (2 * win) @(negedge clk);
            count_hi(2 * win, h);
            chk($sformatf("R2/R4/R5/R6 vector %0d high samples", v), h, int'(VECS[v].exp_hi));
        end

        // R7 single-register mode ignores compare B
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        setup(16'd9, 16'd3, 3'd0, 2'b01, 1'b0);
        wr(3'd3, 16'd7);
        measure_period(9, h);
        chk("R7 width with B written", h, 4);

        // R8 paired mode: A active first, idle write deferred to wrap
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        setup(16'd9, 16'd2, 3'd0, 2'b10, 1'b0);
        measure_period(9, h);
        chk("R8 initial width from A", h, 3);
        wait_strobe();
        @(negedge clk);
        wr(3'd3, 16'd6);
        count_hi(9, h);
        chk("R8 rest of period after idle write", h, 2);
        measure_period(9, h);
        chk("R8 width after swap to B", h, 7);

        // R9 write to active register B acts at once, no swap
        wait_strobe();
        @(negedge clk);
        wr(3'd3, 16'd3);
        count_hi(9, h);
        chk("R9 rest of period after active write", h, 3);
        measure_period(9, h);
        chk("R9 no swap after active write", h, 4);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule